// File: doc/BRIEF.md
# Shader Program Flow Sequencer

This block walks a vertex-shader program for the arithmetic datapath. It holds the program image in a word memory and fetches one instruction per cycle from a program counter. Arithmetic instructions are handed to the datapath as a fetched word with a one-cycle valid strobe. Subroutine entry and exit are handled inside the block, using a small return stack. Any of eight load strobes writes the memory. Each write stores the load data at an internal write pointer and advances that pointer. A separate pointer-clear input restarts the fill at word zero.

A run begins with a start pulse. The program counter is then loaded from an entry-offset input. The return stack is refilled so that every entry holds an all-ones marker. Execution continues until a return instruction finds that marker on top of the stack. At that point the block drops busy and raises a one-cycle done pulse. A subroutine entry attempted with all eight stack entries in use sets a sticky overflow flag and ends the run. An opcode the block does not know sets a sticky flag and is otherwise skipped.

Top module: `vsh_flow_seq`

## Requirements
- R1: While reset is asserted, and after it is released, `busy`, `done`, `instr_vld`, `stk_ovf` and `bad_op` are all low until a start is accepted.
- R2: Each cycle with any bit of `ld_wr` set stores `ld_data` once, at the write pointer, and then advances the pointer by one. The pointer wraps from the last word to word 0. `ld_begin` alone sets the pointer to 0.
- R3: When `ld_begin` and a load strobe are both high in one cycle, the word is stored at address 0 and the pointer becomes 1.
- R4: A start in idle loads the program counter from the low 10 bits of `entry_ofs`; the upper bits are ignored. The same start refills the stack with all-ones markers and clears both sticky flags. `busy` is high from the next cycle. A start that arrives while `busy` is high has no effect.
- R5: The opcode sits in bits [31:26]. The datapath opcodes are 0x00, 0x01, 0x02, 0x08, 0x0C, 0x0D, 0x0E, 0x0F and 0x13. Each one produces exactly one `instr_vld` cycle carrying the full 32-bit word, in program order, and then execution moves to the next address.
- R6: Opcode 0x22 (flush) produces no `instr_vld` and moves on to the next address.
- R7: Opcode 0x24 (call) pushes its own address and jumps to the word address held in bits [21:10] (low 10 bits used). It produces no `instr_vld`.
- R8: Opcode 0x21 (return) on a stack whose top is not the marker pops the stack. Execution resumes at the popped address plus one.
- R9: A return that finds the all-ones marker on top ends the run. `busy` falls and `done` is high for exactly one cycle on the same edge.
- R10: Eight nested calls run normally. A call issued while all eight entries are in use sets `stk_ovf` and ends the run with a done pulse. `stk_ovf` stays set until the next accepted start.
- R11: Any other opcode sets `bad_op`, which stays set until the next accepted start. That opcode produces no `instr_vld` and execution moves to the next address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_begin | input | 1 | Clear the program write pointer |
| ld_wr | input | 8 | Eight equivalent word-write strobes |
| ld_data | input | 32 | Program word to store |
| entry_ofs | input | 16 | Run entry word offset |
| start | input | 1 | Begin a run (honoured only when idle) |
| instr | output | 32 | Last datapath instruction word |
| instr_vld | output | 1 | One-cycle strobe qualifying `instr` |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| stk_ovf | output | 1 | Sticky: a call was issued with the stack full |
| bad_op | output | 1 | Sticky: an unknown opcode was fetched |

## Verification
The pointer clear and a word write can fall in the same cycle. The bench provokes this with `ld_begin` and a load strobe driven together, followed by one plain write. Both words are then judged by running a program from entry 0 and checking that the fetched instructions are exactly those two words, in order. A second collision case is a start that arrives in the middle of a run. The bench judges it by checking that the scoreboard sees an unchanged instruction stream, with no flags raised.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

  typedef enum logic [5:0] {
    OP_ADD  = 6'h00,
    OP_DP3  = 6'h01,
    OP_DP4  = 6'h02,
    OP_MUL  = 6'h08,
    OP_MAX  = 6'h0C,
    OP_MIN  = 6'h0D,
    OP_RCP  = 6'h0E,
    OP_RSQ  = 6'h0F,
    OP_MOV  = 6'h13,
    OP_RET  = 6'h21,
    OP_FLS  = 6'h22,
    OP_CALL = 6'h24
  } op_e;

  typedef enum logic [2:0] {
    K_DATA,
    K_SKIP,
    K_CALL,
    K_RET,
    K_BAD
  } op_kind_e;

  function automatic op_kind_e classify(input logic [5:0] op);
    op_kind_e k;
    case (op)
      OP_ADD, OP_DP3, OP_DP4, OP_MUL, OP_MAX,
      OP_MIN, OP_RCP, OP_RSQ, OP_MOV: k = K_DATA;
      OP_FLS:  k = K_SKIP;
      OP_CALL: k = K_CALL;
      OP_RET:  k = K_RET;
      default: k = K_BAD;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/vseq_prog_mem.sv
module vseq_prog_mem #(
  parameter int DEPTH = 1024,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_begin,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, waddr;

  // pointer clear takes effect before a same-cycle write
  always_comb begin
    waddr  = ld_begin ? '0 : wptr_q;
    wptr_d = wptr_q;
    if (wr)            wptr_d = waddr + 1'b1;
    else if (ld_begin) wptr_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wptr_q <= '0;
    else        wptr_q <= wptr_d;
  end

  always_ff @(posedge clk) begin
    if (wr) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

  // R2: plain write advances pointer by one
  a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !ld_begin) |=> (wptr_q == $past(wptr_q) + 1'b1));

  // R3: clear plus write leaves pointer at one
  a_r3_begin_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && ld_begin) |=> (wptr_q == AW'(1)));

endmodule

// File: rtl/vseq_ret_stack.sv
module vseq_ret_stack #(
  parameter int NENT = 8,
  parameter int SW   = 32,
  localparam int CW  = $clog2(NENT + 1),
  localparam int IW  = $clog2(NENT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          refill,
  input  logic          push,
  input  logic          pop,
  input  logic [SW-1:0] push_val,
  output logic [SW-1:0] top,
  output logic          full
);

  logic [SW-1:0] ent_q [NENT];
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] top_idx, push_idx;

  assign top_idx  = (cnt_q == '0) ? '0 : IW'(cnt_q - 1'b1);
  assign push_idx = IW'(cnt_q);
  assign top      = ent_q[top_idx];
  assign full     = (cnt_q == CW'(NENT));

  always_comb begin
    cnt_d = cnt_q;
    if (refill)    cnt_d = '0;
    else if (push) cnt_d = cnt_q + 1'b1;
    else if (pop)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // each entry returns to the all-ones marker on refill or when popped
  for (genvar g = 0; g < NENT; g++) begin : g_ent
    logic we;
    logic [SW-1:0] wv;
    always_comb begin
      we = 1'b0;
      wv = ent_q[g];
      if (refill) begin
        we = 1'b1;
        wv = '1;
      end else if (push && push_idx == IW'(g)) begin
        we = 1'b1;
        wv = push_val;
      end else if (pop && top_idx == IW'(g)) begin
        we = 1'b1;
        wv = '1;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ent_q[g] <= '1;
      else if (we) ent_q[g] <= wv;
    end
  end

  // R10: a push never lands on a full stack
  a_r10_push_room: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q < CW'(NENT)));

  // R8: a pop never hits an empty stack
  a_r8_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0));

endmodule

// File: rtl/vseq_flow_ctrl.sv
module vseq_flow_ctrl
  import vseq_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 32,
  parameter int SW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] entry,
  input  logic [DW-1:0] fetch,
  input  logic [SW-1:0] stk_top,
  input  logic          stk_full,
  output logic [AW-1:0] pc,
  output logic          stk_refill,
  output logic          stk_push,
  output logic          stk_pop,
  output logic [SW-1:0] stk_val,
  output logic [DW-1:0] instr,
  output logic          instr_vld,
  output logic          busy,
  output logic          done,
  output logic          stk_ovf,
  output logic          bad_op
);

  localparam int TGT_LSB = 10;

  logic          run_q, run_d;
  logic [AW-1:0] pc_q, pc_d;
  logic [DW-1:0] ins_q, ins_d;
  logic          vld_q, vld_d, done_q, done_d;
  logic          ovf_q, ovf_d, bad_q, bad_d;
  op_kind_e      kind;
  logic          at_marker;

  assign kind      = classify(fetch[DW-1 -: 6]);
  assign at_marker = (stk_top == '1);
  assign stk_val   = SW'(pc_q);

  always_comb begin
    run_d      = run_q;
    pc_d       = pc_q;
    ins_d      = ins_q;
    vld_d      = 1'b0;
    done_d     = 1'b0;
    ovf_d      = ovf_q;
    bad_d      = bad_q;
    stk_refill = 1'b0;
    stk_push   = 1'b0;
    stk_pop    = 1'b0;
    if (!run_q) begin
      if (start) begin
        run_d      = 1'b1;
        pc_d       = entry;
        ovf_d      = 1'b0;
        bad_d      = 1'b0;
        stk_refill = 1'b1;
      end
    end else begin
      case (kind)
        K_DATA: begin
          vld_d = 1'b1;
          ins_d = fetch;
          pc_d  = pc_q + 1'b1;
        end
        K_SKIP: pc_d = pc_q + 1'b1;
        K_CALL: begin
          if (stk_full) begin
            ovf_d  = 1'b1;
            run_d  = 1'b0;
            done_d = 1'b1;
          end else begin
            stk_push = 1'b1;
            pc_d     = fetch[TGT_LSB +: AW];
          end
        end
        K_RET: begin
          if (at_marker) begin
            run_d  = 1'b0;
            done_d = 1'b1;
          end else begin
            stk_pop = 1'b1;
            pc_d    = stk_top[AW-1:0] + 1'b1;
          end
        end
        default: begin
          bad_d = 1'b1;
          pc_d  = pc_q + 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pc_q   <= '0;
      ins_q  <= '0;
      vld_q  <= 1'b0;
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      run_q  <= run_d;
      pc_q   <= pc_d;
      ins_q  <= ins_d;
      vld_q  <= vld_d;
      done_q <= done_d;
      ovf_q  <= ovf_d;
      bad_q  <= bad_d;
    end
  end

  assign pc        = pc_q;
  assign instr     = ins_q;
  assign instr_vld = vld_q;
  assign busy      = run_q;
  assign done      = done_q;
  assign stk_ovf   = ovf_q;
  assign bad_op    = bad_q;

  // R9: done lasts one cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R9: busy falls on the edge that raises done
  a_r9_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!run_q && $past(run_q)));

  // R5: a datapath strobe only follows a running cycle
  a_r5_vld_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $past(run_q));

  // R11: unknown-opcode flag is sticky until an accepted start
  a_r11_bad_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_q && !(start && !run_q)) |=> bad_q);

  // R10: overflow flag is sticky until an accepted start
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !(start && !run_q)) |=> ovf_q);

endmodule

// File: rtl/vsh_flow_seq.sv
module vsh_flow_seq #(
  parameter int DEPTH = 1024,
  parameter int DW    = 32,
  parameter int NSTK  = 8,
  parameter int EW    = 16,
  parameter int NSTB  = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_begin,
  input  logic [NSTB-1:0] ld_wr,
  input  logic [DW-1:0]   ld_data,
  input  logic [EW-1:0]   entry_ofs,
  input  logic            start,
  output logic [DW-1:0]   instr,
  output logic            instr_vld,
  output logic            busy,
  output logic            done,
  output logic            stk_ovf,
  output logic            bad_op
);

  logic [AW-1:0] pc;
  logic [DW-1:0] fetch;
  logic [DW-1:0] stk_top, stk_val;
  logic          stk_full, stk_refill, stk_push, stk_pop;
  logic          unused_entry_hi;

  assign unused_entry_hi = ^entry_ofs[EW-1:AW];

  vseq_prog_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_begin (ld_begin),
    .wr       (|ld_wr),
    .wdata    (ld_data),
    .raddr    (pc),
    .rdata    (fetch)
  );

  vseq_ret_stack #(.NENT(NSTK), .SW(DW)) u_stk (
    .clk      (clk),
    .rst_n    (rst_n),
    .refill   (stk_refill),
    .push     (stk_push),
    .pop      (stk_pop),
    .push_val (stk_val),
    .top      (stk_top),
    .full     (stk_full)
  );

  vseq_flow_ctrl #(.AW(AW), .DW(DW), .SW(DW)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .entry      (entry_ofs[AW-1:0]),
    .fetch      (fetch),
    .stk_top    (stk_top),
    .stk_full   (stk_full),
    .pc         (pc),
    .stk_refill (stk_refill),
    .stk_push   (stk_push),
    .stk_pop    (stk_pop),
    .stk_val    (stk_val),
    .instr      (instr),
    .instr_vld  (instr_vld),
    .busy       (busy),
    .done       (done),
    .stk_ovf    (stk_ovf),
    .bad_op     (bad_op)
  );

endmodule

// File: tb/vsh_flow_seq_test.sv
module vsh_flow_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_begin = 1'b0;
  logic [7:0]  ld_wr = '0;
  logic [31:0] ld_data = '0;
  logic [15:0] entry_ofs = '0;
  logic        start = 1'b0;
  logic [31:0] instr;
  logic        instr_vld, busy, done, stk_ovf, bad_op;

  int nvec = 0;
  int nbad = 0;
  int cyc  = 0;
  logic [31:0] expq[$];
  logic [31:0] img [1024];

  always #10 clk = ~clk;

  vsh_flow_seq uut (
    .clk(clk), .rst_n(rst_n), .ld_begin(ld_begin), .ld_wr(ld_wr),
    .ld_data(ld_data), .entry_ofs(entry_ofs), .start(start),
    .instr(instr), .instr_vld(instr_vld), .busy(busy), .done(done),
    .stk_ovf(stk_ovf), .bad_op(bad_op)
  );

  function automatic logic [31:0] dw(input logic [5:0] op, input int tag);
    return {op, 26'(tag)};
  endfunction
  function automatic logic [31:0] callw(input int tgt);
    return {6'h24, 4'h0, 12'(tgt), 10'h0};
  endfunction
  function automatic logic [31:0] retw();
    return {6'h21, 26'h0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // scoreboard monitor: R5 order and contents of datapath strobes
  always @(negedge clk) begin
    if (rst_n && instr_vld) begin
      if (expq.size() == 0) chk("R5 unexpected strobe", instr, 32'hxxxx_xxxx);
      else chk("R5 strobe word", instr, expq.pop_front());
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nbad++;
      nvec++;
      $display("FAIL watchdog: actual %0d expected <150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  task automatic ld_word(input logic [31:0] d, input logic [7:0] stb, input logic clr);
    @(negedge clk);
    ld_data = d; ld_wr = stb; ld_begin = clr;
    @(negedge clk);
    ld_wr = '0; ld_begin = 1'b0;
  endtask

  task automatic run(input string tag, input logic [15:0] ent,
                     input logic e_ovf, input logic e_bad, input logic poke);
    bit seen = 0;
    @(negedge clk);
    entry_ofs = ent; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({"R4 busy after start ", tag}, busy, 1'b1);
    for (int n = 0; n < 4000; n++) begin
      if (poke && n == 2) begin entry_ofs = 16'h0300; start = 1'b1; end
      if (poke && n == 3) start = 1'b0;
      if (done) begin seen = 1; break; end
      @(negedge clk);
    end
    start = 1'b0;
    chk({"R9 done seen ", tag}, seen, 1'b1);
    chk({"R9 busy low at done ", tag}, busy, 1'b0);
    chk({"R5 queue drained ", tag}, expq.size(), 0);
    chk({"R10 overflow flag ", tag}, stk_ovf, e_ovf);
    chk({"R11 bad opcode flag ", tag}, bad_op, e_bad);
    @(negedge clk);
    chk({"R9 done one cycle ", tag}, done, 1'b0);
    expq.delete();
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) img[i] = dw(6'h00, 16'h7700 + i);
    img[1] = retw();
    // program A at 0x10 with subroutine at 0x20 (R6, R7, R8)
    img[16'h10] = dw(6'h00, 1);
    img[16'h11] = dw(6'h08, 2);
    img[16'h12] = callw(16'h20);
    img[16'h13] = dw(6'h13, 3);
    img[16'h14] = retw();
    img[16'h20] = dw(6'h02, 4);
    img[16'h21] = {6'h22, 26'h0};
    img[16'h22] = retw();
    // program B at 0x40: unknown opcode among datapath ops (R11)
    img[16'h40] = dw(6'h01, 5);
    img[16'h41] = dw(6'h3F, 0);
    img[16'h42] = dw(6'h0C, 6);
    img[16'h43] = dw(6'h0D, 7);
    img[16'h44] = dw(6'h0E, 8);
    img[16'h45] = dw(6'h0F, 9);
    img[16'h46] = retw();
    // chain of 8 calls at 0x200, chain of 9 calls at 0x300 (R10)
    for (int k = 0; k < 8; k++) begin
      img[16'h200 + 2*k]     = callw(16'h200 + 2*k + 2);
      img[16'h200 + 2*k + 1] = retw();
    end
    img[16'h210] = dw(6'h13, 16'hA);
    img[16'h211] = retw();
    for (int k = 0; k < 9; k++) begin
      img[16'h300 + 2*k]     = callw(16'h300 + 2*k + 2);
      img[16'h300 + 2*k + 1] = retw();
    end
    img[16'h312] = dw(6'h13, 16'hB);
    img[16'h313] = retw();

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 1'b0);
    chk("R1 done", done, 1'b0);
    chk("R1 instr_vld", instr_vld, 1'b0);
    chk("R1 stk_ovf", stk_ovf, 1'b0);
    chk("R1 bad_op", bad_op, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 busy after release", busy, 1'b0);

    // R2 fill through rotating strobes
    @(negedge clk);
    ld_begin = 1'b1;
    @(negedge clk);
    ld_begin = 1'b0;
    for (int i = 0; i < 1024; i++) begin
      ld_data = img[i]; ld_wr = 8'h1 << (i % 8);
      @(negedge clk);
    end
    ld_wr = '0;

    expq.push_back(img[16'h10]); expq.push_back(img[16'h11]);
    expq.push_back(img[16'h20]); expq.push_back(img[16'h13]);
    run("R7 R8 call return", 16'h0010, 1'b0, 1'b0, 1'b0);

    expq.push_back(img[16'h40]); expq.push_back(img[16'h42]);
    expq.push_back(img[16'h43]); expq.push_back(img[16'h44]);
    expq.push_back(img[16'h45]);
    run("R11 unknown op", 16'h0040, 1'b0, 1'b1, 1'b0);

    expq.push_back(img[16'h210]);
    run("R10 eight deep", 16'h0200, 1'b0, 1'b0, 1'b0);

    run("R10 ninth call", 16'h0300, 1'b1, 1'b0, 1'b0);

    // R4: high entry bits ignored, flags cleared, mid-run start ignored
    expq.push_back(img[16'h10]); expq.push_back(img[16'h11]);
    expq.push_back(img[16'h20]); expq.push_back(img[16'h13]);
    run("R4 start while busy", 16'hFC10, 1'b0, 1'b0, 1'b1);

    // R2 wrap: pointer is past the last word, next write lands at word 0
    ld_word(dw(6'h13, 16'hC), 8'h20, 1'b0);
    expq.push_back(dw(6'h13, 16'hC));
    run("R2 pointer wrap", 16'h0000, 1'b0, 1'b0, 1'b0);

    // R3: clear and write together, then a multi-strobe write at word 1
    ld_word(dw(6'h08, 16'hD), 8'h04, 1'b1);
    ld_word(dw(6'h00, 16'hE), 8'h42, 1'b0);
    ld_word(retw(), 8'h80, 1'b0);
    expq.push_back(dw(6'h08, 16'hD));
    expq.push_back(dw(6'h00, 16'hE));
    run("R3 clear with write", 16'h0000, 1'b0, 1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule